// File: doc/BRIEF.md
# DDR SDRAM power-up and refresh sequencer

This block sits on the command side of a DDR SDRAM controller. It takes a graphics DDR SDRAM from power-on to a usable state. After reset it keeps the clock-enable pin low through a long stable-clock interval. It then raises clock enable and issues a fixed, ordered list of commands: precharge-all, the extended mode register write, a mode register write that resets the DLL, a second precharge-all, two auto-refreshes, and a final mode register write that clears the DLL reset bit. It leaves time for the DLL to lock and then raises a ready flag.

Once ready, the block issues an auto-refresh command at a fixed interval. A one-cycle strobe marks each refresh so that logic outside the block can hold back user traffic during that cycle. Every wait is counted by a single down-counter. Its load values are worked out at elaboration from the clock period and the timing values in nanoseconds. The CAS latency written to the mode register is chosen from the clock period.

Top module: `sdram_init_seq`

## Requirements
- R1: For the first N_PU = ceil(POWERUP_NS*1000/CLK_PERIOD_PS) cycles after reset, cke_o is low and the command is NOP. cke_o rises one cycle before the first command and stays high after that.
- R2: The first command is precharge-all: {ras_n,cas_n,we_n}=010, addr bit 10 high, all other address bits 0, ba=0.
- R3: The extended mode register write is {ras_n,cas_n,we_n}=000 with ba=01 (bank bit 0 high). Address bit 0 is 1 when the DLL is disabled. Address bit 1 is 1 for reduced drive strength. All other address bits are 0. It follows the precharge after ceil(TRP_NS*1000/CLK_PERIOD_PS) cycles.
- R4: No mode register write (000 with ba=00) appears before the extended mode register write. The first mode register write follows the extended mode register write after TMRD_CYC cycles.
- R5: A mode register write carries these fields: burst length code in address bits 2:0 (2→1, 4→2, 8→3), burst type in bit 3 (1 = interleaved), CAS latency in bits 6:4, and DLL reset in bit 8. The first write has bit 8 set and the last has it clear.
- R6: The CAS latency is 3 when CLK_PERIOD_PS ≥ 5000 and 4 otherwise.
- R7: After the DLL-reset write the sequence is: precharge-all after TMRD_CYC cycles, an auto-refresh ({ras_n,cas_n,we_n}=001) after one more tRP, a second auto-refresh after tRFC, and the final mode register write after another tRFC.
- R8: ready_o rises exactly max(TMRD_CYC, DLL_LOCK_CYC − cycles from the DLL-reset write to the final write) cycles after the final mode register write. This is no fewer than DLL_LOCK_CYC cycles after the DLL-reset write. ready_o then stays high.
- R9: Once ready_o is high, an auto-refresh is issued every ceil(TREFI_NS*1000/CLK_PERIOD_PS) cycles, the first one a full interval after ready. ref_tick_o is high in exactly those cycles, and no other command is issued.
- R10: cs_n_o is low from reset on. Every cycle that carries no command shows NOP ({ras_n,cas_n,we_n}=111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock, same as the memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address / mode word |
| ready_o | output | 1 | Initialization complete |
| ref_tick_o | output | 1 | High in each cycle that carries a periodic refresh |

## Verification
The main instance uses a 4 ns period, which selects CAS latency 4. It is built with a 2 µs power-up interval and a 400 ns refresh interval, so the whole sequence and five periodic refreshes fit in about 1200 cycles. It also uses burst length 8, interleaved bursts and reduced drive, so every mode field carries a non-zero value. A second instance runs with a 5 ns period and default mode settings. It exercises the CAS latency 3 branch and the other values of the mode fields. The DLL lock window is placed so that the final gap is set by the lock time rather than by tMRD.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_CKE, ST_PREA1, ST_EMRS, ST_MRS_DLL, ST_PREA2,
    ST_REF1, ST_REF2, ST_MRS, ST_READY, ST_RUN
  } step_e;

  function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                            input longint unsigned ps);
    longint unsigned c;
    c = (ns * 1000 + ps - 1) / ps;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned cas_for_period(input int unsigned ps);
    return (ps >= 5000) ? 3 : 4;
  endfunction

  function automatic logic [2:0] bl_code(input int unsigned bl);
    case (bl)
      8:       return 3'd3;
      4:       return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_mode_words.sv
module sdram_mode_words
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned CAS_LAT     = 3,
  parameter int unsigned BURST_LEN   = 4,
  parameter bit          INTERLEAVE  = 1'b0,
  parameter bit          DRV_REDUCED = 1'b0,
  parameter bit          DLL_DISABLE = 1'b0
) (
  output logic [ADDR_W-1:0] emrs_w_o,
  output logic [ADDR_W-1:0] mrs_w_o
);
  localparam int unsigned PAD_W = ADDR_W - 9;
  localparam logic [2:0] CL_CODE = 3'(CAS_LAT);

  logic [8:0] mrs_low;
  logic [8:0] emrs_low;

  assign mrs_low  = {1'b0, 1'b0, CL_CODE, INTERLEAVE, bl_code(BURST_LEN)};
  assign emrs_low = {7'd0, DRV_REDUCED, DLL_DISABLE};

  generate
    if (PAD_W > 0) begin : g_pad
      assign mrs_w_o  = {{PAD_W{1'b0}}, mrs_low};
      assign emrs_w_o = {{PAD_W{1'b0}}, emrs_low};
    end else begin : g_nopad
      assign mrs_w_o  = mrs_low[ADDR_W-1:0];
      assign emrs_w_o = emrs_low[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sdram_wait_cnt.sv
module sdram_wait_cnt #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R1: a load only happens when the previous wait has run out
  a_r1_load_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> zero_o);
endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_set_i,
  input  logic              rdy_set_i,
  input  logic              tick_i,
  input  cmd_e              cmd_i,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o,
  output logic              ref_tick_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o      <= 1'b0;
      cs_n_o     <= 1'b0;
      {ras_n_o, cas_n_o, we_n_o} <= CMD_NOP;
      ba_o       <= '0;
      addr_o     <= '0;
      ready_o    <= 1'b0;
      ref_tick_o <= 1'b0;
    end else begin
      if (cke_set_i) cke_o <= 1'b1;
      if (rdy_set_i) ready_o <= 1'b1;
      cs_n_o     <= 1'b0;
      {ras_n_o, cas_n_o, we_n_o} <= cmd_i;
      ba_o       <= ba_i;
      addr_o     <= addr_i;
      ref_tick_o <= tick_i;
    end
  end

  // R8: ready is sticky
  a_r8_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  // R1: clock enable never drops once raised
  a_r1_cke_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS    = 5000,
  parameter int unsigned POWERUP_NS       = 200000,
  parameter int unsigned TRP_NS           = 15,
  parameter int unsigned TRFC_NS          = 70,
  parameter int unsigned TMRD_CYC         = 2,
  parameter int unsigned TREFI_NS         = 7800,
  parameter int unsigned DLL_LOCK_CYC     = 200,
  parameter int unsigned BURST_LEN        = 4,
  parameter bit          BURST_INTERLEAVE = 1'b0,
  parameter bit          DRV_REDUCED      = 1'b0,
  parameter bit          DLL_DISABLE      = 1'b0,
  parameter int unsigned ADDR_W           = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o,
  output logic              ref_tick_o
);
  localparam int unsigned N_PU   = ns_to_cyc(POWERUP_NS, CLK_PERIOD_PS);
  localparam int unsigned N_RP   = ns_to_cyc(TRP_NS, CLK_PERIOD_PS);
  localparam int unsigned N_RFC  = ns_to_cyc(TRFC_NS, CLK_PERIOD_PS);
  localparam int unsigned N_REFI = ns_to_cyc(TREFI_NS, CLK_PERIOD_PS);
  localparam int unsigned N_MRD  = max2(TMRD_CYC, 1);
  localparam int unsigned CAS    = cas_for_period(CLK_PERIOD_PS);
  // cycles already spent between the DLL-reset write and the final write
  localparam int unsigned USED   = N_MRD + N_RP + 2 * N_RFC;
  localparam int unsigned GAP_FIN = (DLL_LOCK_CYC > USED + N_MRD) ? DLL_LOCK_CYC - USED : N_MRD;
  localparam int unsigned MAX_CYC = max2(max2(N_PU, N_REFI), max2(GAP_FIN, max2(N_RFC, N_RP)));
  localparam int unsigned CNT_W  = $clog2(MAX_CYC + 1);
  localparam int unsigned AGE_W  = $clog2(DLL_LOCK_CYC + 2);

  localparam logic [CNT_W-1:0] LV_RP   = CNT_W'(N_RP - 1);
  localparam logic [CNT_W-1:0] LV_RFC  = CNT_W'(N_RFC - 1);
  localparam logic [CNT_W-1:0] LV_MRD  = CNT_W'(N_MRD - 1);
  localparam logic [CNT_W-1:0] LV_FIN  = CNT_W'(GAP_FIN - 1);
  localparam logic [CNT_W-1:0] LV_REFI = CNT_W'(N_REFI - 1);

  logic [ADDR_W-1:0] emrs_w, mrs_w;
  logic              zero, load;
  logic [CNT_W-1:0]  load_val;
  step_e             step_q, step_d;
  cmd_e              cmd_d;
  logic [1:0]        ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic              cke_set, rdy_set, tick;
  logic              emrs_done_q;

  sdram_mode_words #(
    .ADDR_W(ADDR_W), .CAS_LAT(CAS), .BURST_LEN(BURST_LEN),
    .INTERLEAVE(BURST_INTERLEAVE), .DRV_REDUCED(DRV_REDUCED), .DLL_DISABLE(DLL_DISABLE)
  ) u_words (
    .emrs_w_o(emrs_w),
    .mrs_w_o (mrs_w)
  );

  sdram_wait_cnt #(.CNT_W(CNT_W), .RST_VAL(N_PU - 1)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (zero)
  );

  always_comb begin
    step_d   = step_q;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    addr_d   = '0;
    load     = 1'b0;
    load_val = '0;
    cke_set  = 1'b0;
    rdy_set  = 1'b0;
    tick     = 1'b0;
    if (zero) begin
      load = 1'b1;
      unique case (step_q)
        ST_CKE: begin
          cke_set = 1'b1;
          step_d  = ST_PREA1;
        end
        ST_PREA1, ST_PREA2: begin
          cmd_d      = CMD_PRE;
          addr_d[10] = 1'b1;
          load_val   = LV_RP;
          step_d     = (step_q == ST_PREA1) ? ST_EMRS : ST_REF1;
        end
        ST_EMRS: begin
          cmd_d    = CMD_MRS;
          ba_d     = 2'b01;
          addr_d   = emrs_w;
          load_val = LV_MRD;
          step_d   = ST_MRS_DLL;
        end
        ST_MRS_DLL: begin
          cmd_d     = CMD_MRS;
          addr_d    = mrs_w;
          addr_d[8] = 1'b1;
          load_val  = LV_MRD;
          step_d    = ST_PREA2;
        end
        ST_REF1, ST_REF2: begin
          cmd_d    = CMD_REF;
          load_val = LV_RFC;
          step_d   = (step_q == ST_REF1) ? ST_REF2 : ST_MRS;
        end
        ST_MRS: begin
          cmd_d    = CMD_MRS;
          addr_d   = mrs_w;
          load_val = LV_FIN;
          step_d   = ST_READY;
        end
        ST_READY: begin
          rdy_set  = 1'b1;
          load_val = LV_REFI;
          step_d   = ST_RUN;
        end
        ST_RUN: begin
          cmd_d    = CMD_REF;
          tick     = 1'b1;
          load_val = LV_REFI;
        end
        default: step_d = ST_CKE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q      <= ST_CKE;
      emrs_done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      if (zero && step_q == ST_EMRS) emrs_done_q <= 1'b1;
    end
  end

  sdram_cmd_reg #(.ADDR_W(ADDR_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cke_set_i (cke_set),
    .rdy_set_i (rdy_set),
    .tick_i    (tick),
    .cmd_i     (cmd_d),
    .ba_i      (ba_d),
    .addr_i    (addr_d),
    .cke_o     (cke_o),
    .cs_n_o    (cs_n_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o),
    .we_n_o    (we_n_o),
    .ba_o      (ba_o),
    .addr_o    (addr_o),
    .ready_o   (ready_o),
    .ref_tick_o(ref_tick_o)
  );

  // cycles since the DLL-reset write appeared on the pins, saturating
  logic [AGE_W-1:0] dll_age_q;
  logic             dll_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_age_q  <= '0;
      dll_seen_q <= 1'b0;
    end else if ({ras_n_o, cas_n_o, we_n_o} == CMD_MRS && ba_o == 2'b00 && addr_o[8]) begin
      dll_seen_q <= 1'b1;
      dll_age_q  <= AGE_W'(1);
    end else if (dll_seen_q && dll_age_q <= AGE_W'(DLL_LOCK_CYC)) begin
      dll_age_q <= dll_age_q + 1'b1;
    end
  end

  // R1: no command while clock enable is low
  a_r1_nop_while_cke_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> ({ras_n_o, cas_n_o, we_n_o} == CMD_NOP));
  // R2: every precharge is precharge-all
  a_r2_prea_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({ras_n_o, cas_n_o, we_n_o} == CMD_PRE) |-> addr_o[10]);
  // R4: mode register write only after the extended one
  a_r4_emrs_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({ras_n_o, cas_n_o, we_n_o} == CMD_MRS && ba_o == 2'b00) |-> emrs_done_q);
  // R8: ready only after the DLL lock window
  a_r8_dll_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (dll_seen_q && dll_age_q >= AGE_W'(DLL_LOCK_CYC)));
  // R9: the refresh strobe marks a refresh command
  a_r9_tick_is_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_tick_o |-> ({ras_n_o, cas_n_o, we_n_o} == CMD_REF && ready_o));
  // R10: chip select stays asserted
  a_r10_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o);
endmodule

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;
  localparam int CLK_NS   = 4;
  localparam int CLK3_NS  = 5;
  localparam int PU_NS    = 2000;
  localparam int RP_NS    = 15;
  localparam int RFC_NS   = 60;
  localparam int MRD      = 2;
  localparam int REFI_NS  = 400;
  localparam int LOCK     = 200;

  function automatic int cyc_of(input int ns, input int pns);
    return (ns * 1000 + pns * 1000 - 1) / (pns * 1000);
  endfunction

  localparam int E_PU   = cyc_of(PU_NS, CLK_NS);
  localparam int E_RP   = cyc_of(RP_NS, CLK_NS);
  localparam int E_RFC  = cyc_of(RFC_NS, CLK_NS);
  localparam int E_REFI = cyc_of(REFI_NS, CLK_NS);

  logic clk = 0, clk3 = 0, rst_n = 0;
  always #(CLK_NS / 2.0) clk = ~clk;
  always #(CLK3_NS / 2.0) clk3 = ~clk3;

  logic cke, cs_n, ras_n, cas_n, we_n, ready, tick;
  logic [1:0] ba;
  logic [12:0] addr;
  logic cke3, cs_n3, ras_n3, cas_n3, we_n3, ready3, tick3;
  logic [1:0] ba3;
  logic [12:0] addr3;

  sdram_init_seq #(
    .CLK_PERIOD_PS(CLK_NS * 1000), .POWERUP_NS(PU_NS), .TRP_NS(RP_NS), .TRFC_NS(RFC_NS),
    .TMRD_CYC(MRD), .TREFI_NS(REFI_NS), .DLL_LOCK_CYC(LOCK), .BURST_LEN(8),
    .BURST_INTERLEAVE(1'b1), .DRV_REDUCED(1'b1), .DLL_DISABLE(1'b0), .ADDR_W(13)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .ready_o(ready),
    .ref_tick_o(tick)
  );

  sdram_init_seq #(
    .CLK_PERIOD_PS(CLK3_NS * 1000), .POWERUP_NS(PU_NS), .TRP_NS(RP_NS), .TRFC_NS(RFC_NS),
    .TMRD_CYC(MRD), .TREFI_NS(REFI_NS), .DLL_LOCK_CYC(LOCK), .ADDR_W(13)
  ) uut_cl3 (
    .clk_i(clk3), .rst_ni(rst_n), .cke_o(cke3), .cs_n_o(cs_n3), .ras_n_o(ras_n3),
    .cas_n_o(cas_n3), .we_n_o(we_n3), .ba_o(ba3), .addr_o(addr3), .ready_o(ready3),
    .ref_tick_o(tick3)
  );

  typedef struct {
    int          cyc;
    logic [2:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  int cyc = 0;
  int t_ready = 0, t_ref0 = 0, t_end = 0;
  int cl3_seen = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input int c, input logic [2:0] k, input logic [1:0] b,
                          input logic [12:0] a, input string r);
    exp_t e;
    e.cyc = c; e.cmd = k; e.ba = b; e.addr = a; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic build_schedule();
    int t, t_dll, fin;
    t = E_PU + 1;
    push_exp(t, 3'b010, 2'b00, 13'h400, "R2");                // precharge-all
    t += E_RP;
    push_exp(t, 3'b000, 2'b01, 13'h002, "R3");                // EMRS, reduced drive
    t += MRD; t_dll = t;
    push_exp(t, 3'b000, 2'b00, 13'h14B, "R4/R5");             // CL4, interleave, BL8, DLL reset
    t += MRD;
    push_exp(t, 3'b010, 2'b00, 13'h400, "R7");
    t += E_RP;
    push_exp(t, 3'b001, 2'b00, 13'h000, "R7");
    t += E_RFC;
    push_exp(t, 3'b001, 2'b00, 13'h000, "R7");
    t += E_RFC;
    push_exp(t, 3'b000, 2'b00, 13'h04B, "R5/R7");
    fin = LOCK - (t - t_dll);
    if (fin < MRD) fin = MRD;
    t_ready = t + fin;
    t_ref0 = t_ready + E_REFI;
    for (int i = 0; i < 5; i++)
      push_exp(t_ref0 + i * E_REFI, 3'b001, 2'b00, 13'h000, "R9");
    t_end = t_ref0 + 4 * E_REFI + 5;
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      check(cke == 0 && {ras_n, cas_n, we_n} == 3'b111 && ready == 0 && tick == 0,
            "R1", "reset state", {cke, ras_n, cas_n, we_n, ready, tick}, 6'b011100);
    end else if (!done) begin
      check(cs_n == 1'b0, "R10", "cs_n", cs_n, 0);
      check(cke == (cyc >= E_PU), "R1", $sformatf("cke at %0d", cyc), cke, cyc >= E_PU);
      check(ready == (cyc >= t_ready), "R8", $sformatf("ready at %0d", cyc), ready, cyc >= t_ready);
      check(tick == (cyc >= t_ref0 && (cyc - t_ref0) % E_REFI == 0), "R9",
            $sformatf("ref tick at %0d", cyc), tick, (cyc >= t_ref0 && (cyc - t_ref0) % E_REFI == 0));
      if ({ras_n, cas_n, we_n} != 3'b111) begin
        if (exp_q.size() == 0) begin
          check(0, "R10", $sformatf("unexpected command at %0d", cyc), {ras_n, cas_n, we_n}, 3'b111);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.cyc, e.req, "command cycle", cyc, e.cyc);
          check({ras_n, cas_n, we_n} == e.cmd, e.req, "command code", {ras_n, cas_n, we_n}, e.cmd);
          check(ba == e.ba, e.req, "bank", ba, e.ba);
          check(addr == e.addr, e.req, "address", addr, e.addr);
        end
      end
    end
  end

  // second instance: CAS latency 3, BL4 sequential, DLL reset then clear
  always @(negedge clk3) begin
    if (rst_n && !done && {ras_n3, cas_n3, we_n3} == 3'b000 && ba3 == 2'b00) begin
      check(addr3[6:4] == 3'd3, "R6", "cas latency at 5 ns", addr3[6:4], 3);
      check(addr3 == (cl3_seen == 0 ? 13'h132 : 13'h032), "R5", "mode word at 5 ns",
            addr3, (cl3_seen == 0 ? 13'h132 : 13'h032));
      cl3_seen++;
    end
  end

  initial begin
    build_schedule();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    wait (cyc >= t_end);
    @(negedge clk);
    done = 1;
    check(exp_q.size() == 0, "R9", "commands left unseen", exp_q.size(), 0);
    check(cl3_seen == 2, "R6", "mode writes at 5 ns", cl3_seen, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected end %0d", cyc, t_end);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule